// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block chooses the address that a 32-bit, five-stage RISC pipeline fetches next. Each cycle it receives the instruction that sits in the register-read stage together with that instruction's own address. A dedicated adder there forms the jump or PC-relative branch target. One clock later, when the instruction reaches the execute stage, the two register operands arrive and a small comparator settles the outcome. No condition flags are kept anywhere: equality, inequality and sign tests run on the raw register values.

When the control transfer is taken, the block presents the target as the fetch address during that same execute cycle and raises a one-cycle redirect pulse. Upstream logic uses that pulse to discard the single wrong-path instruction that was fetched in between. A taken transfer therefore costs exactly one fetch slot. In every other cycle the fetch address steps on by four from the previous fetch address.

Top module: `npc_unit`

## Requirements
- R1: After one or more clock edges with `rst_n` low, `fetch_pc` equals the `RESET_PC` parameter (default 0x0000_1000) and `redirect` is low.
- R2: In a cycle with no redirect, `fetch_pc` equals the previous cycle's `fetch_pc` plus 4.
- R3: Opcode 0x02 at `rd_instr[31:26]` is an unconditional jump. It is always taken, and its target is `{rd_pc[31:28], rd_instr[25:0], 2'b00}`.
- R4: Conditional branches take their target as `rd_pc` plus the 16-bit offset at `rd_instr[15:0]`, which is sign-extended and shifted left by two.
- R5: Opcode 0x04 is taken when `ex_rs_val == ex_rt_val`. Opcode 0x05 is taken when the two values differ.
- R6: Four opcodes test `ex_rs_val` as a signed number against zero, with `ex_rt_val` ignored: 0x01 taken when less than zero, 0x06 when less or equal, 0x07 when greater than zero, 0x03 when greater or equal. All other opcodes are not control transfers.
- R7: A control instruction with `rd_valid` high in cycle t is resolved in cycle t+1 using the operands given in t+1. If it is taken, `redirect` is high in t+1 only and `fetch_pc` equals its target in t+1. If it is not taken, `redirect` stays low.
- R8: A control instruction in the register-read stage during a redirect cycle is the wrong-path instruction. It causes no redirect in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Register-read stage holds a valid instruction |
| rd_pc | input | 32 | Address of the register-read stage instruction (word aligned) |
| rd_instr | input | 32 | Instruction word in the register-read stage |
| ex_rs_val | input | 32 | First register operand of the execute stage instruction |
| ex_rt_val | input | 32 | Second register operand of the execute stage instruction |
| fetch_pc | output | 32 | Address to fetch in the current cycle |
| redirect | output | 1 | Taken control transfer: flush the one wrong-path instruction |

## Verification
The target is latched at the edge that closes the register-read cycle. The decision and the new fetch address then appear combinationally in the next cycle, from operands driven in that cycle, so a control instruction presented in cycle t shows its effect in cycle t+1 with no further delay. The sequential step takes effect across each edge. The bench drives every input just after the falling edge, lets the combinational outputs settle, and compares `fetch_pc` and `redirect` on every cycle against a behavioural model. The model advances at the rising edge and holds a single pending control instruction.

// File: rtl/npc_pkg.sv
// Shared constants and types of the next-PC unit.
// Assumes 32-bit instruction words: opcode in the top six bits.
package npc_pkg;
    parameter int unsigned XLEN = 32;

    localparam int unsigned INSN_W   = 32;
    localparam int unsigned OPC_W    = 6;
    localparam int unsigned OPC_LSB  = INSN_W - OPC_W;
    localparam int unsigned OFS_W    = 16;
    localparam int unsigned JIDX_W   = 26;
    localparam int unsigned REGION_W = 4;
    localparam int unsigned ALIGN_W  = 2;
    localparam int unsigned FILL_W   = XLEN - OFS_W - ALIGN_W;

    localparam logic [OPC_W-1:0] OPC_JUMP   = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BR_EQ  = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BR_NE  = 6'h05;
    localparam logic [OPC_W-1:0] OPC_BR_LTZ = 6'h01;
    localparam logic [OPC_W-1:0] OPC_BR_LEZ = 6'h06;
    localparam logic [OPC_W-1:0] OPC_BR_GTZ = 6'h07;
    localparam logic [OPC_W-1:0] OPC_BR_GEZ = 6'h03;

    typedef enum logic [2:0] {
        FK_NONE,
        FK_JUMP,
        FK_EQ,
        FK_NE,
        FK_LTZ,
        FK_LEZ,
        FK_GTZ,
        FK_GEZ
    } flow_kind_e;
endpackage

// File: rtl/npc_rd_target.sv
// Register-read stage: classifies the instruction and forms its target
// with a dedicated adder (not the ALU). Assumes rd_pc_i is word aligned.
module npc_rd_target
    import npc_pkg::*;
(
    input  logic              rd_valid_i,
    input  logic [XLEN-1:0]   rd_pc_i,
    input  logic [INSN_W-1:0] rd_instr_i,
    output flow_kind_e        kind_o,
    output logic [XLEN-1:0]   target_o
);
    logic [OPC_W-1:0] opc;
    logic [XLEN-1:0]  rel_ofs;
    logic [XLEN-1:0]  abs_tgt;

    assign opc = rd_instr_i[OPC_LSB +: OPC_W];

    // Opcode to control-flow kind; invalid slots carry no kind.
    always_comb begin
        kind_o = FK_NONE;
        if (rd_valid_i) begin
            case (opc)
                OPC_JUMP:   kind_o = FK_JUMP;
                OPC_BR_EQ:  kind_o = FK_EQ;
                OPC_BR_NE:  kind_o = FK_NE;
                OPC_BR_LTZ: kind_o = FK_LTZ;
                OPC_BR_LEZ: kind_o = FK_LEZ;
                OPC_BR_GTZ: kind_o = FK_GTZ;
                OPC_BR_GEZ: kind_o = FK_GEZ;
                default:    kind_o = FK_NONE;
            endcase
        end
    end

    // Sign-extended, word-scaled branch offset.
    assign rel_ofs = {{FILL_W{rd_instr_i[OFS_W-1]}}, rd_instr_i[OFS_W-1:0], {ALIGN_W{1'b0}}};

    // Absolute jump address inside the current 256 MiB region.
    assign abs_tgt = {rd_pc_i[XLEN-1 -: REGION_W], rd_instr_i[JIDX_W-1:0], {ALIGN_W{1'b0}}};

    // Target select: jump region address or PC-relative sum.
    always_comb begin
        if (kind_o == FK_JUMP) target_o = abs_tgt;
        else                   target_o = rd_pc_i + rel_ofs;
    end
endmodule

// File: rtl/npc_ex_slot.sv
// Pipeline register between register-read and execute for the single
// pending control instruction. Cleared by reset and by a redirect, which
// squashes the wrong-path instruction then in register-read.
module npc_ex_slot
    import npc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill_i,
    input  flow_kind_e      kind_i,
    input  logic [XLEN-1:0] target_i,
    input  logic [XLEN-1:0] pc_i,
    output logic            valid_o,
    output flow_kind_e      kind_o,
    output logic [XLEN-1:0] target_o
);
    // Capture a control instruction unless the current cycle redirects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            kind_o   <= FK_NONE;
            target_o <= '0;
        end else begin
            valid_o  <= !kill_i && (kind_i != FK_NONE);
            kind_o   <= kill_i ? FK_NONE : kind_i;
            target_o <= target_i;
        end
    end

    // A held jump target keeps the region bits of its own PC.
    assert_jump_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == FK_JUMP && !kill_i) |=> (target_o[XLEN-1 -: REGION_W] == $past(pc_i[XLEN-1 -: REGION_W])));

    // A redirect leaves nothing pending in the next cycle.
    assert_squash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> !valid_o);

    // Targets from aligned PCs stay word aligned.
    assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (target_o[ALIGN_W-1:0] == '0));
endmodule

// File: rtl/npc_cond_eval.sv
// Execute stage comparator: equality and sign tests on raw register values,
// with no stored condition flags. Jumps always resolve as taken.
module npc_cond_eval
    import npc_pkg::*;
(
    input  flow_kind_e      kind_i,
    input  logic [XLEN-1:0] rs_i,
    input  logic [XLEN-1:0] rt_i,
    output logic            take_o
);
    logic rs_neg;
    logic rs_zero;
    logic same;

    assign rs_neg  = rs_i[XLEN-1];
    assign rs_zero = (rs_i == '0);
    assign same    = (rs_i == rt_i);

    // Decision per control-flow kind.
    always_comb begin
        case (kind_i)
            FK_JUMP: take_o = 1'b1;
            FK_EQ:   take_o = same;
            FK_NE:   take_o = !same;
            FK_LTZ:  take_o = rs_neg;
            FK_LEZ:  take_o = rs_neg || rs_zero;
            FK_GTZ:  take_o = !rs_neg && !rs_zero;
            FK_GEZ:  take_o = !rs_neg;
            default: take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_pc_seq.sv
// Fetch address sequencer: the fetch address is the redirect target when one
// is taken, otherwise the held sequential address; the register then steps
// four bytes past whatever was fetched.
module npc_pc_seq
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect_i,
    input  logic [XLEN-1:0] target_i,
    output logic [XLEN-1:0] fetch_pc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] seq_q;

    // Steer the target in ahead of the fetch access.
    assign fetch_pc_o = redirect_i ? target_i : seq_q;

    // Hold the address that follows the one fetched now.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= RESET_PC;
        else        seq_q <= fetch_pc_o + STEP;
    end

    // Without a redirect the fetch address steps by four.
    assert_step_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (redirect_i || fetch_pc_o == $past(fetch_pc_o) + STEP));

    // A redirect is a single pulse and fetching continues after the target.
    assert_pulse_then_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (!redirect_i && fetch_pc_o == $past(target_i) + STEP));
endmodule

// File: rtl/npc_unit.sv
// Next-PC unit top: target formed in register-read, decided in execute,
// one-cycle redirect on any taken transfer. Assumes rd_pc is word aligned
// and that upstream drops its instruction when redirect is high.
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [XLEN-1:0]   rd_pc,
    input  logic [INSN_W-1:0] rd_instr,
    input  logic [XLEN-1:0]   ex_rs_val,
    input  logic [XLEN-1:0]   ex_rt_val,
    output logic [XLEN-1:0]   fetch_pc,
    output logic              redirect
);
    flow_kind_e      rd_kind;
    logic [XLEN-1:0] rd_target;
    logic            ex_valid;
    flow_kind_e      ex_kind;
    logic [XLEN-1:0] ex_target;
    logic            ex_take;

    npc_rd_target u_rd (
        .rd_valid_i (rd_valid),
        .rd_pc_i    (rd_pc),
        .rd_instr_i (rd_instr),
        .kind_o     (rd_kind),
        .target_o   (rd_target)
    );

    npc_ex_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill_i   (redirect),
        .kind_i   (rd_kind),
        .target_i (rd_target),
        .pc_i     (rd_pc),
        .valid_o  (ex_valid),
        .kind_o   (ex_kind),
        .target_o (ex_target)
    );

    npc_cond_eval u_cmp (
        .kind_i (ex_kind),
        .rs_i   (ex_rs_val),
        .rt_i   (ex_rt_val),
        .take_o (ex_take)
    );

    // Redirect only for a live, taken control instruction.
    assign redirect = ex_valid && ex_take;

    npc_pc_seq #(.RESET_PC(RESET_PC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .redirect_i (redirect),
        .target_i   (ex_target),
        .fetch_pc_o (fetch_pc)
    );

    // An equality branch redirects only on matching operands.
    assert_eq_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && ex_kind == FK_EQ) |-> (ex_rs_val == ex_rt_val));

    // A greater-than-zero branch redirects only on a positive operand.
    assert_gtz_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && ex_kind == FK_GTZ) |-> ($signed(ex_rs_val) > 0));

    // A redirect needs a valid control instruction in the previous cycle.
    assert_redirect_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(rd_valid));
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb_top;
    localparam logic [31:0] RST_ADDR = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_pc = '0;
    logic [31:0] rd_instr = '0;
    logic [31:0] ex_rs_val = '0;
    logic [31:0] ex_rt_val = '0;
    logic [31:0] fetch_pc;
    logic        redirect;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural model state.
    logic [31:0] m_pc;
    bit          m_pend;
    logic [5:0]  m_op;
    logic [31:0] m_tgt;

    always #10 clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_pc(rd_pc),
        .rd_instr(rd_instr), .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val),
        .fetch_pc(fetch_pc), .redirect(redirect)
    );

    function automatic bit is_ctl(input logic [5:0] op);
        return op inside {6'h02, 6'h04, 6'h05, 6'h01, 6'h06, 6'h07, 6'h03};
    endfunction

    function automatic bit model_take(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        int signed sa;
        sa = $signed(a);
        case (op)
            6'h02: return 1;
            6'h04: return a == b;
            6'h05: return a != b;
            6'h01: return sa < 0;
            6'h06: return sa <= 0;
            6'h07: return sa > 0;
            6'h03: return sa >= 0;
            default: return 0;
        endcase
    endfunction

    // One cycle: drive, settle, compare, advance the model at the edge.
    task automatic cyc(input bit v, input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
        bit          e_red;
        logic [31:0] e_pc;
        rd_valid = v; rd_pc = pc; rd_instr = ins; ex_rs_val = a; ex_rt_val = b;
        #2;
        e_red = m_pend && model_take(m_op, a, b);
        e_pc  = e_red ? m_tgt : m_pc;
        total++;
        if (fetch_pc !== e_pc || redirect !== e_red) begin
            bad++;
            $display("FAIL %s fetch_pc=%h exp=%h redirect=%b exp=%b", tag, fetch_pc, e_pc, redirect, e_red);
        end
        @(posedge clk);
        m_pc = e_pc + 4;
        m_pend = !e_red && v && is_ctl(ins[31:26]);
        m_op = ins[31:26];
        if (ins[31:26] == 6'h02) m_tgt = {pc[31:28], ins[25:0], 2'b00};
        else m_tgt = pc + {{14{ins[15]}}, ins[15:0], 2'b00};
        @(negedge clk);
    endtask

    // Present a control instruction, then resolve it with operands a, b.
    task automatic ctl(input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
        cyc(1, pc, ins, 32'h0, 32'h0, tag);
        cyc(0, 32'h0, 32'h0, a, b, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog fetch_pc=%h exp=done redirect=%b exp=done", fetch_pc, redirect);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_pc = RST_ADDR; m_pend = 0; m_op = '0; m_tgt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cyc(0, 32'h0, 32'h0, 32'h0, 32'h0, "R1");
        // R2: sequential stepping, non-control opcodes ignored
        for (int i = 0; i < 4; i++) cyc(1, 32'h2000, {6'h23, 26'h0}, 32'h5, 32'h5, "R2");
        // R3: jump with high region bits
        ctl(32'hF000_0100, {6'h02, 26'h3AB_CDEF}, 32'h1, 32'h2, "R3");
        ctl(32'h7FFF_FFFC, {6'h02, 26'h000_0001}, 32'h0, 32'h0, "R3");
        // R4, R5: equality branches, forward and backward offsets
        ctl(32'h0000_4000, {6'h04, 5'd1, 5'd2, 16'hFFF0}, 32'h1234, 32'h1234, "R4 R5 beq taken back");
        ctl(32'h0000_4000, {6'h04, 5'd1, 5'd2, 16'h7FFF}, 32'h1234, 32'h1235, "R5 beq not taken");
        ctl(32'h0000_4000, {6'h05, 5'd1, 5'd2, 16'h7FFF}, 32'h1234, 32'h1235, "R4 R5 bne taken fwd");
        ctl(32'h0000_0000, {6'h05, 5'd1, 5'd2, 16'h8000}, 32'h9, 32'h9, "R5 bne not taken");
        ctl(32'h0002_0000, {6'h05, 5'd1, 5'd2, 16'h8000}, 32'h9, 32'h8, "R4 min offset");
        // R6: sign tests at zero, one, minus one, most negative
        begin
            logic [5:0]  ops [4] = '{6'h01, 6'h06, 6'h07, 6'h03};
            logic [31:0] vals[4] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000};
            foreach (ops[k]) foreach (vals[j])
                ctl(32'h0000_8000, {ops[k], 5'd3, 5'd0, 16'h0010}, vals[j], ~vals[j], "R6");
        end
        // R7: separated jumps give separate pulses; not-taken gives none
        ctl(32'h1000_0000, {6'h02, 26'h10}, 32'h0, 32'h0, "R7 first");
        ctl(32'h1000_0000, {6'h02, 26'h20}, 32'h0, 32'h0, "R7 second");
        cyc(0, 32'h0, 32'h0, 32'h0, 32'h0, "R7 no repeat");
        // R8: control instruction in RD during redirect is squashed
        cyc(1, 32'h0000_3000, {6'h04, 5'd1, 5'd1, 16'h0040}, 32'h0, 32'h0, "R8 setup");
        cyc(1, 32'h0000_3004, {6'h02, 26'h0ABC}, 32'h7, 32'h7, "R8 redirect");
        cyc(0, 32'h0, 32'h0, 32'h0, 32'h0, "R8 squashed");
        // Mixed stream: R2 R5 R6 R7 R8
        for (int n = 0; n < 600; n++) begin
            logic [5:0] op;
            op = ($urandom_range(0, 3) == 0) ? 6'h20 : 6'($urandom_range(1, 7));
            cyc($urandom_range(0, 4) != 0, {$urandom, 2'b00} & 32'hFFFF_FFFC,
                {op, 10'($urandom), 16'($urandom)},
                32'($signed(4'($urandom))), 32'($signed(4'($urandom))), "R7 mixed");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule